// File: doc/BRIEF.md
# Processor Status Flag Register

This block is the status word of a small 8-bit processor core. It keeps the four arithmetic condition flags (carry, half carry, zero, overflow) next to two system flags that record why the core last stopped or restarted: a power-down flag and a watchdog-expiry flag. The arithmetic flags follow whatever the ALU last reported. Software can also overwrite them through an ordinary data-memory write at the register's address.

The two system flags cannot be changed by software at all. They move only on core events. Power-up clears them. The halt instruction sets the power-down flag and clears the expiry flag. The clear-watchdog instruction clears both. A watchdog expiry sets the expiry flag. The watchdog counter and the sleep controller sit outside this block and deliver one-cycle strobes. The register value is presented combinationally from the flops for bus reads. The two top bits always read as zero.

Top module: `status_flag_reg`

## Requirements
- R1: While the active-low power-up reset `por_n` is low, and on the first cycle after it is released, `stat_o` reads 8'h00.
- R2: A bus write (`bus_we_i`=1) with `bus_addr_i` equal to `STAT_ADDR` (default 8'h0A) loads `bus_wdata_i[3:0]` into bits 3:0 (bit 0 carry, bit 1 half carry, bit 2 zero, bit 3 overflow). The new value is visible on `stat_o` after the next rising clock edge.
- R3: A bus write never changes bit 4 (power-down) or bit 5 (expiry). Bits 7:6 always read 0.
- R4: A bus write to any address other than `STAT_ADDR`, or with `bus_we_i`=0, leaves `stat_o` unchanged.
- R5: For each i in 0..3 with `alu_upd_i[i]`=1, bit i takes `alu_val_i[i]` after the next edge. Bits whose update enable is 0 hold their value.
- R6: When a matching bus write and ALU updates arrive in the same cycle, bits 3:0 take the bus data and the ALU inputs are discarded.
- R7: `halt_i` sets bit 4 and clears bit 5, unless `wdt_to_i` is also high.
- R8: `clrwdt_i` alone clears bits 4 and 5.
- R9: `wdt_to_i` sets bit 5 even when `clrwdt_i` or `halt_i` is high in the same cycle.
- R10: When `halt_i` and `clrwdt_i` are both high, bit 4 ends up set.
- R11: With no write, no ALU update and no event strobe, `stat_o` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Active-low asynchronous power-up reset |
| alu_upd_i | input | 4 | Per-flag update enables from the ALU (C, AC, Z, OV) |
| alu_val_i | input | 4 | New flag values from the ALU |
| bus_we_i | input | 1 | Data-memory write strobe |
| bus_addr_i | input | 8 | Data-memory write address |
| bus_wdata_i | input | 8 | Data-memory write data |
| halt_i | input | 1 | Halt instruction executed (one-cycle strobe) |
| clrwdt_i | input | 1 | Clear-watchdog instruction executed (one-cycle strobe) |
| wdt_to_i | input | 1 | Watchdog expiry (one-cycle strobe) |
| stat_o | output | 8 | Register value for bus reads |

## Verification
Every result of this block shows up on `stat_o` exactly one rising edge after the inputs that cause it, because a single flop stage sits between any input and the output. The bench drives each stimulus on a falling edge and lets exactly one rising edge pass. It then updates its own model of the flags and compares `stat_o` at the following falling edge. The assertions use the same one-cycle spacing through `|=>`. The only exception is reset, which the bench checks while `por_n` is still low and again right after release.

// File: rtl/stat_pkg.sv
package stat_pkg;

  localparam int unsigned DATA_W  = 8;
  localparam int unsigned N_ARITH = 4;
  localparam int unsigned C_BIT   = 0;
  localparam int unsigned AC_BIT  = 1;
  localparam int unsigned Z_BIT   = 2;
  localparam int unsigned OV_BIT  = 3;
  localparam int unsigned PDF_BIT = 4;
  localparam int unsigned TO_BIT  = 5;

  typedef struct packed {
    logic expiry;
    logic pdown;
  } sys_flags_t;

  typedef struct packed {
    logic halt;
    logic clrwdt;
    logic wdt_to;
  } sys_evt_t;

  // One arithmetic flag: the bus write outranks the ALU update.
  function automatic logic arith_bit_next(logic cur, logic bus_hit, logic bus_bit,
                                          logic upd, logic val);
    logic nxt;
    if (bus_hit)  nxt = bus_bit;
    else if (upd) nxt = val;
    else          nxt = cur;
    return nxt;
  endfunction

  // System flags: expiry outranks both instructions; halt outranks clear for power-down.
  function automatic sys_flags_t sys_flags_next(sys_flags_t cur, sys_evt_t ev);
    sys_flags_t nxt;
    nxt = cur;
    if (ev.wdt_to)                 nxt.expiry = 1'b1;
    else if (ev.clrwdt || ev.halt) nxt.expiry = 1'b0;
    if (ev.halt)                   nxt.pdown  = 1'b1;
    else if (ev.clrwdt)            nxt.pdown  = 1'b0;
    return nxt;
  endfunction

  function automatic logic [DATA_W-1:0] pack_status(logic [N_ARITH-1:0] ar, sys_flags_t sf);
    logic [DATA_W-1:0] w;
    w = '0;
    w[N_ARITH-1:0] = ar;
    w[PDF_BIT]     = sf.pdown;
    w[TO_BIT]      = sf.expiry;
    return w;
  endfunction

endpackage

// File: rtl/stat_addr_match.sv
module stat_addr_match #(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] MATCH = 8'h0A
) (
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  assign hit_o = we_i && (addr_i == MATCH);
endmodule

// File: rtl/stat_arith_flags.sv
module stat_arith_flags #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic         bus_hit_i,
  input  logic [N-1:0] bus_bits_i,
  input  logic [N-1:0] upd_i,
  input  logic [N-1:0] val_i,
  output logic [N-1:0] flags_o
);
  import stat_pkg::*;

  for (genvar i = 0; i < N; i++) begin : g_flag
    logic q;
    logic d;
    always_comb d = arith_bit_next(q, bus_hit_i, bus_bits_i[i], upd_i[i], val_i[i]);
    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) q <= 1'b0;
      else        q <= d;
    end
    assign flags_o[i] = q;
  end
endmodule

// File: rtl/stat_sys_flags.sv
module stat_sys_flags (
  input  logic                 clk,
  input  logic                 por_n,
  input  stat_pkg::sys_evt_t   ev_i,
  output stat_pkg::sys_flags_t flags_o
);
  import stat_pkg::*;

  sys_flags_t q;
  sys_flags_t d;

  always_comb d = sys_flags_next(q, ev_i);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) q <= '0;
    else        q <= d;
  end

  assign flags_o = q;
endmodule

// File: rtl/status_flag_reg.sv
module status_flag_reg #(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h0A
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic [3:0]        alu_upd_i,
  input  logic [3:0]        alu_val_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [7:0]        bus_wdata_i,
  input  logic              halt_i,
  input  logic              clrwdt_i,
  input  logic              wdt_to_i,
  output logic [7:0]        stat_o
);
  import stat_pkg::*;

  localparam int unsigned NA = N_ARITH;

  // Named internal events, visible to the checker.
  logic               bus_hit;
  logic [NA-1:0]      arith_q;
  sys_evt_t           sys_ev;
  sys_flags_t         sys_q;

  stat_addr_match #(.ADDR_W(ADDR_W), .MATCH(STAT_ADDR)) u_match (
    .we_i  (bus_we_i),
    .addr_i(bus_addr_i),
    .hit_o (bus_hit)
  );

  stat_arith_flags #(.N(NA)) u_arith (
    .clk       (clk),
    .por_n     (por_n),
    .bus_hit_i (bus_hit),
    .bus_bits_i(bus_wdata_i[NA-1:0]),
    .upd_i     (alu_upd_i),
    .val_i     (alu_val_i),
    .flags_o   (arith_q)
  );

  always_comb begin
    sys_ev.halt   = halt_i;
    sys_ev.clrwdt = clrwdt_i;
    sys_ev.wdt_to = wdt_to_i;
  end

  stat_sys_flags u_sys (
    .clk    (clk),
    .por_n  (por_n),
    .ev_i   (sys_ev),
    .flags_o(sys_q)
  );

  assign stat_o = pack_status(arith_q, sys_q);

endmodule

// File: rtl/status_flag_reg_chk.sv
module status_flag_reg_chk (
  input logic       clk,
  input logic       por_n,
  input logic       bus_hit,
  input logic [3:0] alu_upd_i,
  input logic [7:0] bus_wdata_i,
  input logic       halt_i,
  input logic       clrwdt_i,
  input logic       wdt_to_i,
  input logic [7:0] stat_o
);
  // R3: software never touches the protected flags
  a_r3_protected: assert property (@(posedge clk) disable iff (!por_n)
    (bus_hit && !halt_i && !clrwdt_i && !wdt_to_i) |=> (stat_o[5:4] == $past(stat_o[5:4])));

  // R3: top bits always read zero
  a_r3_pad_zero: assert property (@(posedge clk) disable iff (!por_n)
    stat_o[7:6] == 2'b00);

  // R2 / R6: matching write lands in bits 3:0, whatever the ALU says
  a_r6_bus_wins: assert property (@(posedge clk) disable iff (!por_n)
    bus_hit |=> (stat_o[3:0] == $past(bus_wdata_i[3:0])));

  // R9: expiry always sets TO
  a_r9_expiry_sets: assert property (@(posedge clk) disable iff (!por_n)
    wdt_to_i |=> stat_o[5]);

  // R7 / R10: halt sets PDF
  a_r7_halt: assert property (@(posedge clk) disable iff (!por_n)
    halt_i |=> stat_o[4]);

  // R7: halt without expiry clears TO
  a_r7_halt_to: assert property (@(posedge clk) disable iff (!por_n)
    (halt_i && !wdt_to_i) |=> !stat_o[5]);

  // R8: clear-watchdog alone clears both system flags
  a_r8_clear: assert property (@(posedge clk) disable iff (!por_n)
    (clrwdt_i && !halt_i && !wdt_to_i) |=> (stat_o[5:4] == 2'b00));

  // R11: quiet cycle holds the register
  a_r11_hold: assert property (@(posedge clk) disable iff (!por_n)
    (!bus_hit && alu_upd_i == 4'd0 && !halt_i && !clrwdt_i && !wdt_to_i) |=> $stable(stat_o));
endmodule

bind status_flag_reg status_flag_reg_chk u_chk (
  .clk        (clk),
  .por_n      (por_n),
  .bus_hit    (bus_hit),
  .alu_upd_i  (alu_upd_i),
  .bus_wdata_i(bus_wdata_i),
  .halt_i     (halt_i),
  .clrwdt_i   (clrwdt_i),
  .wdt_to_i   (wdt_to_i),
  .stat_o     (stat_o)
);

// File: tb/status_flag_reg_test.sv
module status_flag_reg_test;
  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic [3:0] alu_upd_i = '0;
  logic [3:0] alu_val_i = '0;
  logic       bus_we_i = 1'b0;
  logic [7:0] bus_addr_i = '0;
  logic [7:0] bus_wdata_i = '0;
  logic       halt_i = 1'b0;
  logic       clrwdt_i = 1'b0;
  logic       wdt_to_i = 1'b0;
  logic [7:0] stat_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;
  logic [7:0] model = 8'h00;

  always #10 clk = ~clk;  // 50 MHz

  status_flag_reg uut (
    .clk(clk), .por_n(por_n), .alu_upd_i(alu_upd_i), .alu_val_i(alu_val_i),
    .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
    .halt_i(halt_i), .clrwdt_i(clrwdt_i), .wdt_to_i(wdt_to_i), .stat_o(stat_o)
  );

  // Bench restatement of the flag rules, written as a per-case table.
  function automatic logic [7:0] predict(logic [7:0] cur, logic we, logic [7:0] addr,
      logic [7:0] wd, logic [3:0] upd, logic [3:0] val, logic h, logic cw, logic wt);
    logic [7:0] n;
    logic [3:0] low;
    logic pd, to;
    low = (cur[3:0] & ~upd) | (val & upd);
    if (we && addr == 8'h0A) low = wd[3:0];
    pd = cur[4];
    to = cur[5];
    case ({h, cw})
      2'b10, 2'b11: pd = 1'b1;
      2'b01:        pd = 1'b0;
      default:      ;
    endcase
    if (wt) to = 1'b1;
    else if (h | cw) to = 1'b0;
    n = {2'b00, to, pd, low};
    return n;
  endfunction

  task automatic check(string tag, logic [7:0] exp);
    n_checks++;
    if (stat_o !== exp) begin
      n_fail++;
      $display("FAIL %s: stat_o=%02h expected=%02h", tag, stat_o, exp);
    end
  endtask

  // Called at a falling edge: drive, pass one rising edge, compare at next falling edge.
  task automatic step(string tag, logic we, logic [7:0] addr, logic [7:0] wd,
      logic [3:0] upd, logic [3:0] val, logic h, logic cw, logic wt);
    bus_we_i = we; bus_addr_i = addr; bus_wdata_i = wd;
    alu_upd_i = upd; alu_val_i = val;
    halt_i = h; clrwdt_i = cw; wdt_to_i = wt;
    @(posedge clk);
    model = predict(model, we, addr, wd, upd, val, h, cw, wt);
    @(negedge clk);
    bus_we_i = 0; alu_upd_i = 0; halt_i = 0; clrwdt_i = 0; wdt_to_i = 0;
    check(tag, model);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R1 during reset", 8'h00);
    por_n = 1'b1;
    @(negedge clk);
    check("R1 after release", 8'h00);

    step("R2 write all ones", 1, 8'h0A, 8'hFF, 4'h0, 4'h0, 0, 0, 0);   // 0F
    step("R4 other address", 1, 8'h0B, 8'h00, 4'h0, 4'h0, 0, 0, 0);
    step("R4 address without strobe", 0, 8'h0A, 8'h00, 4'h0, 4'h0, 0, 0, 0);
    step("R5 partial ALU update", 0, 8'h00, 8'h00, 4'b0101, 4'b0000, 0, 0, 0); // 0A
    step("R6 bus beats ALU", 1, 8'h0A, 8'h03, 4'hF, 4'hC, 0, 0, 0);    // 03
    step("R7 halt", 0, 8'h00, 8'h00, 4'h0, 4'h0, 1, 0, 0);             // 13
    step("R3 write cannot clear PDF", 1, 8'h0A, 8'h00, 4'h0, 4'h0, 0, 0, 0);
    step("R9 expiry", 0, 8'h00, 8'h00, 4'h0, 4'h0, 0, 0, 1);           // 30
    step("R3 write cannot clear TO", 1, 8'h0A, 8'hC0, 4'h0, 4'h0, 0, 0, 0);
    step("R8 clear watchdog", 0, 8'h00, 8'h00, 4'h0, 4'h0, 0, 1, 0);   // 00
    step("R3 write cannot set TO or PDF", 1, 8'h0A, 8'hF5, 4'h0, 4'h0, 0, 0, 0);
    step("R9 expiry beats clear", 0, 8'h00, 8'h00, 4'h0, 4'h0, 0, 1, 1);
    step("R9 expiry beats halt", 0, 8'h00, 8'h00, 4'h0, 4'h0, 1, 0, 1);
    step("R10 halt with clear", 0, 8'h00, 8'h00, 4'h0, 4'h0, 1, 1, 0);
    step("R11 idle hold", 0, 8'h00, 8'h00, 4'h0, 4'h0, 0, 0, 0);

    for (int i = 0; i < 800; i++) begin
      logic we, h, cw, wt;
      logic [7:0] addr, wd;
      logic [3:0] upd, val;
      string tag;
      we   = ($urandom % 3) == 0;
      addr = (($urandom % 2) == 0) ? 8'h0A : 8'($urandom);
      wd   = 8'($urandom);
      upd  = 4'($urandom);
      val  = 4'($urandom);
      h    = ($urandom % 6) == 0;
      cw   = ($urandom % 6) == 0;
      wt   = ($urandom % 8) == 0;
      if (wt)                    tag = "R9 random";
      else if (h && cw)          tag = "R10 random";
      else if (h)                tag = "R7 random";
      else if (cw)               tag = "R8 random";
      else if (we && addr == 8'h0A) tag = (upd != 0) ? "R6 random" : "R2 random";
      else if (upd != 0)         tag = "R5 random";
      else                       tag = "R11 random";
      step(tag, we, addr, wd, upd, val, h, cw, wt);
    end

    // Reset in the middle of activity
    @(negedge clk);
    por_n = 1'b0;
    model = 8'h00;
    #1;
    check("R1 mid-run reset", 8'h00);
    @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
    check("R1 after second release", 8'h00);

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule